// File: doc/BRIEF.md
# Prioritised Interrupt Entry and Cause Unit

This unit keeps the processor's interrupt control word and its interrupt cause word for eight request levels. The six upper levels are driven by hardware request lines and the two lower levels are set and cleared by software. Each cycle it compares the latched requests with the enable mask and the global enable. When an interrupt can be taken, it raises a take pulse and reports the winning level.

On the take edge the unit marks the processor as being in exception state, records an external-interrupt reason, and saves the current mask on a small stack. It then narrows the mask so that only levels above the one taken can interrupt again. A synchronous trap records its own reason code and also saves the mask, so that every entry pairs with one return. A return pulse leaves exception state and puts back the most recently saved mask. Saving processor state and running the handler are left to the surrounding core.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset both register words read as zero, `irq_take_o` is low and `stack_ovf_o` is low.
- R2: The control word (select 0) holds the mask in bits 15:8, a user-mode bit in bit 4, the exception-state bit in bit 1 and the global enable in bit 0, and all other bits read zero. In the cause word (select 1), bit 31 is the branch-delay flag, bits 15:8 are the pending levels (bits 15:10 are hardware lines 5:0, bits 9:8 are software levels 1:0) and bits 6:2 are the reason code. The only writable fields of the cause word are bits 9:8.
- R3: `irq_take_o` is high exactly when the global enable is 1, exception state is 0, no trap is presented that cycle, and at least one pending level has its mask bit set.
- R4: While `irq_take_o` is high, `irq_level_o` is the highest-numbered pending level whose mask bit is set. Level 7 has the highest priority and level 0 the lowest.
- R5: On the take edge, exception state becomes 1, the reason code becomes 0 (external interrupt), the branch-delay flag clears, and every mask bit at or below the taken level is cleared while higher bits keep their values.
- R6: Software pending bits keep the last written value until they are written again. Each hardware pending bit follows its request line after a two-flop synchroniser. Pending bits are held whatever the enable and mask state is.
- R7: A trap pulse records the 5-bit code (4, 5 address errors; 6, 7 bus errors; 8 syscall; 9 breakpoint; 10 reserved instruction; 12 overflow) and the branch-delay input, sets exception state, and leaves the mask unchanged. It suppresses `irq_take_o` in the same cycle.
- R8: A return pulse clears exception state and restores the most recently saved mask. When nothing is saved, the mask is left unchanged.
- R9: Saved masks form a 4-deep last-in first-out stack and every entry (interrupt or trap) pushes one. A push onto a full stack is dropped and sets `stack_ovf_o`, which stays set until reset.
- R10: `irq_take_o` is high for a single cycle for each entry, because the entry itself sets exception state.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines_i | input | 6 | Raw hardware request lines, levels 7..2 |
| trap_valid_i | input | 1 | Synchronous trap presented this cycle |
| trap_code_i | input | 5 | Reason code of the trap |
| trap_in_delay_i | input | 1 | Trapping instruction sits in a branch delay slot |
| ret_i | input | 1 | Return from handler |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_sel_i | input | 1 | Write target: 0 control word, 1 cause word |
| reg_wr_data_i | input | 32 | Write data |
| reg_rd_sel_i | input | 1 | Read source: 0 control word, 1 cause word |
| reg_rd_data_o | output | 32 | Read data, combinational |
| irq_take_o | output | 1 | Interrupt is taken on this edge |
| irq_level_o | output | 3 | Level being taken |
| stack_ovf_o | output | 1 | Sticky mask-stack overflow |

## Verification
A corrupted mask or pending latch shows up on the next cycle, either as a take pulse that should not be there (or one that is missing) or as a wrong level. A badly narrowed mask on entry can be read back from the control word one cycle after the take. A stack that pushes or pops the wrong entry only shows on a later return, when the restored mask is read back, so the bench nests entries to the full depth and unwinds them in order. The sweep covers every pending pattern against several masks, which exposes any ranking or masking error in the level selection at the ports.

// File: rtl/icu_pkg.sv
package icu_pkg;
   // control word field positions
   localparam int CW_IE   = 0;
   localparam int CW_EXL  = 1;
   localparam int CW_UM   = 4;
   localparam int FLD_LO  = 8;   // mask (control) and pending (cause)
   // cause word field positions
   localparam int CS_CODE_LO = 2;
   localparam int CS_BD      = 31;

   typedef enum logic [4:0] {
      RSN_EXT_IRQ  = 5'd0,
      RSN_ADDR_LD  = 5'd4,
      RSN_ADDR_ST  = 5'd5,
      RSN_BUS_IF   = 5'd6,
      RSN_BUS_DATA = 5'd7,
      RSN_SYSCALL  = 5'd8,
      RSN_BREAK    = 5'd9,
      RSN_BAD_INSN = 5'd10,
      RSN_ARITH    = 5'd12
   } reason_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_flops
         logic [STAGES-1:0][W-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
   parameter int N  = 8,
   parameter int LW = 3
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [LW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i]) idx_o = LW'(i);
      end
   end
   assign any_o = |req_i;
endmodule

// File: rtl/icu_mask_stack.sv
module icu_mask_stack #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] top_o,
   output logic         empty_o,
   output logic         full_o,
   output logic         ovf_o
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DEPTH-1:0][W-1:0] slot_q;
   logic [CNT_W-1:0]        cnt_q;
   logic                    ovf_q;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign top_o   = empty_o ? '0 : slot_q[IDX_W'(cnt_q - 1'b1)];
   assign ovf_o   = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
      end else if (push_i) begin
         if (full_o) begin
            ovf_q <= 1'b1;
         end else begin
            slot_q[IDX_W'(cnt_q)] <= din_i;
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (pop_i && !empty_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
   import icu_pkg::*;
#(
   parameter int N_HW        = 6,
   parameter int N_SW        = 2,
   parameter int SYNC_STAGES = 2,
   parameter int STACK_DEPTH = 4,
   parameter int CODE_W      = 5,
   localparam int NLVL       = N_HW + N_SW,
   localparam int LVL_W      = $clog2(NLVL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_HW-1:0]   irq_lines_i,
   input  logic              trap_valid_i,
   input  logic [CODE_W-1:0] trap_code_i,
   input  logic              trap_in_delay_i,
   input  logic              ret_i,
   input  logic              reg_wr_en_i,
   input  logic              reg_wr_sel_i,
   input  logic [31:0]       reg_wr_data_i,
   input  logic              reg_rd_sel_i,
   output logic [31:0]       reg_rd_data_o,
   output logic              irq_take_o,
   output logic [LVL_W-1:0]  irq_level_o,
   output logic              stack_ovf_o
);
   generate
      if (NLVL != 8) begin : g_bad_levels
         $error("irq_cause_unit: hardware plus software levels must total 8");
      end
      if (STACK_DEPTH < 2) begin : g_bad_depth
         $error("irq_cause_unit: STACK_DEPTH must be at least 2");
      end
      if (CODE_W != 5) begin : g_bad_code
         $error("irq_cause_unit: reason code field is 5 bits wide");
      end
   endgenerate

   logic [NLVL-1:0]   mask_q;
   logic              um_q, exl_q, ie_q, bd_q;
   logic [N_SW-1:0]   sw_pend_q;
   logic [CODE_W-1:0] code_q;
   logic [N_HW-1:0]   hw_pend;
   logic [NLVL-1:0]   pend, act, keep;
   logic              any_act, push, pop, ret_eff;
   logic [NLVL-1:0]   stk_top;
   logic              stk_empty, stk_full;

   icu_sync #(.W(N_HW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(irq_lines_i), .q_o(hw_pend)
   );

   assign pend = {hw_pend, sw_pend_q};
   assign act  = pend & mask_q;

   icu_prio #(.N(NLVL), .LW(LVL_W)) u_prio (
      .req_i(act), .any_o(any_act), .idx_o(irq_level_o)
   );

   assign irq_take_o = ie_q & ~exl_q & any_act & ~trap_valid_i;
   assign ret_eff    = ret_i & ~trap_valid_i;
   assign push       = irq_take_o | trap_valid_i;
   assign pop        = ret_eff & ~irq_take_o;

   // levels strictly above the taken one stay open
   always_comb begin
      for (int i = 0; i < NLVL; i++) keep[i] = (LVL_W'(i) > irq_level_o);
   end

   icu_mask_stack #(.W(NLVL), .DEPTH(STACK_DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .din_i(mask_q),
      .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full), .ovf_o(stack_ovf_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         um_q      <= 1'b0;
         exl_q     <= 1'b0;
         ie_q      <= 1'b0;
         bd_q      <= 1'b0;
         sw_pend_q <= '0;
         code_q    <= '0;
      end else begin
         if (reg_wr_en_i && !reg_wr_sel_i) begin
            mask_q <= reg_wr_data_i[FLD_LO +: NLVL];
            um_q   <= reg_wr_data_i[CW_UM];
            exl_q  <= reg_wr_data_i[CW_EXL];
            ie_q   <= reg_wr_data_i[CW_IE];
         end
         if (reg_wr_en_i && reg_wr_sel_i) begin
            sw_pend_q <= reg_wr_data_i[FLD_LO +: N_SW];
         end
         // entry and return events take precedence over a same-cycle write
         if (trap_valid_i) begin
            exl_q  <= 1'b1;
            code_q <= trap_code_i;
            bd_q   <= trap_in_delay_i;
         end else if (irq_take_o) begin
            exl_q  <= 1'b1;
            code_q <= CODE_W'(RSN_EXT_IRQ);
            bd_q   <= 1'b0;
            mask_q <= mask_q & keep;
         end else if (ret_eff) begin
            exl_q <= 1'b0;
            if (!stk_empty) mask_q <= stk_top;
         end
      end
   end

   always_comb begin
      reg_rd_data_o = '0;
      if (!reg_rd_sel_i) begin
         reg_rd_data_o[FLD_LO +: NLVL] = mask_q;
         reg_rd_data_o[CW_UM]          = um_q;
         reg_rd_data_o[CW_EXL]         = exl_q;
         reg_rd_data_o[CW_IE]          = ie_q;
      end else begin
         reg_rd_data_o[CS_BD]                = bd_q;
         reg_rd_data_o[FLD_LO +: NLVL]       = pend;
         reg_rd_data_o[CS_CODE_LO +: CODE_W] = code_q;
      end
   end
endmodule

// File: rtl/irq_cause_unit_chk.sv
module irq_cause_unit_chk #(
   parameter int NLVL  = 8,
   parameter int N_SW  = 2,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_take_o,
   input logic [LVL_W-1:0] irq_level_o,
   input logic [NLVL-1:0]  mask_q,
   input logic [NLVL-1:0]  act,
   input logic             exl_q,
   input logic [N_SW-1:0]  sw_pend_q,
   input logic             reg_wr_en_i,
   input logic             reg_wr_sel_i,
   input logic             ret_i,
   input logic             trap_valid_i,
   input logic [NLVL-1:0]  stk_top,
   input logic             stk_empty,
   input logic             stk_full,
   input logic             stack_ovf_o
);
   a_r4_level_is_top: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_o |-> ((act >> irq_level_o) == NLVL'(1)));

   a_r5_entry_sets_exl: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_o |=> exl_q);

   a_r5_level_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_o |=> !mask_q[$past(irq_level_o)]);

   a_r10_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_o |=> !irq_take_o);

   a_r7_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i |-> !irq_take_o);

   a_r6_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en_i && reg_wr_sel_i) |=> $stable(sw_pend_q));

   a_r8_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !trap_valid_i && !irq_take_o && !stk_empty) |=> (mask_q == $past(stk_top)));

   a_r9_ovf_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stack_ovf_o) |-> $past(stk_full));
endmodule

bind irq_cause_unit irq_cause_unit_chk #(.NLVL(NLVL), .N_SW(N_SW), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_take_o(irq_take_o), .irq_level_o(irq_level_o),
   .mask_q(mask_q), .act(act), .exl_q(exl_q), .sw_pend_q(sw_pend_q),
   .reg_wr_en_i(reg_wr_en_i), .reg_wr_sel_i(reg_wr_sel_i), .ret_i(ret_i),
   .trap_valid_i(trap_valid_i), .stk_top(stk_top), .stk_empty(stk_empty),
   .stk_full(stk_full), .stack_ovf_o(stack_ovf_o)
);

// File: tb/irq_cause_unit_bench.sv
module irq_cause_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  irq_lines = '0;
   logic        trap_valid = 1'b0;
   logic [4:0]  trap_code = '0;
   logic        trap_dly = 1'b0;
   logic        ret = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        take;
   logic [2:0]  level;
   logic        ovf;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_cause_unit u_irq_cause_unit (
      .clk(clk), .rst_n(rst_n), .irq_lines_i(irq_lines), .trap_valid_i(trap_valid),
      .trap_code_i(trap_code), .trap_in_delay_i(trap_dly), .ret_i(ret),
      .reg_wr_en_i(wr_en), .reg_wr_sel_i(wr_sel), .reg_wr_data_i(wr_data),
      .reg_rd_sel_i(rd_sel), .reg_rd_data_o(rd_data), .irq_take_o(take),
      .irq_level_o(level), .stack_ovf_o(ovf)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      rd_sel = sel;
      #1 v = rd_data;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_ret();
      @(negedge clk);
      ret = 1'b1;
      @(negedge clk);
      ret = 1'b0;
   endtask

   task automatic do_trap(input logic [4:0] c, input logic d);
      @(negedge clk);
      trap_valid = 1'b1; trap_code = c; trap_dly = d;
      @(negedge clk);
      trap_valid = 1'b0; trap_dly = 1'b0;
   endtask

   function automatic int top_bit(input logic [7:0] v);
      int r = 0;
      for (int i = 0; i < 8; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      logic [4:0]  codes [8];
      codes = '{5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd12};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1'b0, v); check("R1 control", v, 32'h0);
      rd(1'b1, v); check("R1 cause", v, 32'h0);
      check("R1 take", {31'b0, take}, 32'h0);
      check("R1 ovf", {31'b0, ovf}, 32'h0);

      // R2 field layout
      wr(1'b0, 32'hFFFF_FFFE);
      rd(1'b0, v); check("R2 control fields", v, 32'h0000_FF12);
      wr(1'b0, 32'h0);
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, v); check("R2 cause writable", v, 32'h0000_0300);
      wr(1'b1, 32'h0);

      // R6 synchroniser delay
      @(negedge clk); irq_lines = 6'b000001;
      @(negedge clk); rd(1'b1, v); check("R6 one flop", v, 32'h0);
      @(negedge clk); rd(1'b1, v); check("R6 two flops", v, 32'h0000_0400);
      irq_lines = '0;
      @(negedge clk); @(negedge clk); rd(1'b1, v); check("R6 line drop", v, 32'h0);

      // R3 R4 R5 R8 R10 sweep over all pending patterns
      for (int p = 0; p < 256; p++) begin
         for (int k = 0; k < 2; k++) begin
            logic [7:0] pv, m, a, nm;
            int lv;
            pv = 8'(p);
            m  = (k == 0) ? 8'hFF : 8'((p * 37 + 11) & 255);
            a  = pv & m;
            irq_lines = pv[7:2];
            wr(1'b1, {16'b0, 6'b0, pv[1:0], 8'b0});
            wr(1'b0, {16'b0, m, 8'b0});
            @(negedge clk);
            rd(1'b1, v); check("R6 latched while disabled", {24'b0, v[15:8]}, {24'b0, pv});
            check("R3 disabled", {31'b0, take}, 32'h0);
            wr(1'b0, {16'b0, m, 8'h01});
            check("R3 take", {31'b0, take}, {31'b0, (a != 0)});
            if (a != 0) begin
               lv = top_bit(a);
               check("R4 level", {29'b0, level}, 32'(lv));
               nm = m & ~8'(((2 << lv) - 1) & 255);
               @(negedge clk);
               rd(1'b0, v); check("R5 mask and state", v, {16'b0, nm, 8'h03});
               rd(1'b1, v); check("R5 reason", {27'b0, v[6:2]}, 32'h0);
               check("R10 single pulse", {31'b0, take}, 32'h0);
               wr(1'b0, {16'b0, nm, 8'h02});
               do_ret();
               rd(1'b0, v); check("R8 restore", v, {16'b0, m, 8'h00});
            end else begin
               wr(1'b0, 32'h0);
            end
         end
      end
      irq_lines = '0;
      wr(1'b1, 32'h0);

      // R7 trap codes and branch delay
      wr(1'b0, 32'h0000_5A00);
      for (int j = 0; j < 8; j++) begin
         do_trap(codes[j], j[0]);
         rd(1'b1, v);
         check("R7 code", {27'b0, v[6:2]}, {27'b0, codes[j]});
         check("R7 delay", {31'b0, v[31]}, {31'b0, j[0]});
         rd(1'b0, v); check("R7 control", v, 32'h0000_5A02);
         do_ret();
         rd(1'b0, v); check("R8 after trap", v, 32'h0000_5A00);
      end

      // R7 trap beats a ready interrupt
      wr(1'b1, 32'h0000_0200);
      wr(1'b0, 32'h0000_FF01);
      check("R3 ready", {31'b0, take}, 32'h1);
      trap_valid = 1'b1; trap_code = 5'd8;
      #1 check("R7 suppress take", {31'b0, take}, 32'h0);
      @(negedge clk);
      trap_valid = 1'b0;
      rd(1'b1, v); check("R7 trap reason", {27'b0, v[6:2]}, 32'd8);
      rd(1'b0, v); check("R7 mask kept", v, 32'h0000_FF03);
      wr(1'b0, 32'h0000_FF02);
      do_ret();
      wr(1'b1, 32'h0);
      rd(1'b0, v); check("R8 exl cleared", v, 32'h0000_FF00);

      // R9 stack depth, overflow and order
      for (int j = 1; j <= 5; j++) begin
         wr(1'b0, {16'b0, 8'(j * 17), 8'h02});
         if (j == 5) check("R9 no ovf at depth", {31'b0, ovf}, 32'h0);
         do_trap(5'd9, 1'b0);
      end
      check("R9 ovf set", {31'b0, ovf}, 32'h1);
      for (int j = 4; j >= 1; j--) begin
         do_ret();
         rd(1'b0, v); check("R9 pop order", {24'b0, v[15:8]}, 32'(j * 17));
      end
      do_ret();
      rd(1'b0, v); check("R8 empty ret", {24'b0, v[15:8]}, 32'h11);
      check("R9 ovf sticky", {31'b0, ovf}, 32'h1);

      done = 1;
      finish_run();
   end
endmodule